// File: doc/BRIEF.md
# Selectable-Latency Pipelined Signed Multiplier

This block multiplies two 27-bit two's-complement operands and returns the exact 54-bit signed product. The latency from operands to product is chosen at elaboration, anywhere from 0 to 4 clock cycles. It sits in arithmetic datapaths where the surrounding timing budget decides how many register stages the multiply may absorb.

Four optional register banks can be placed in the path: an operand bank at the input, a partial-product bank, a combined-product bank and a result bank at the output. The partial-product bank holds two partial products, formed by splitting the second operand at bit 18. A latency parameter and a variant parameter together pick the set of banks. Latencies 1 and 3 each have two variants that place their registers at different points in the datapath. A pair that is not supported stops elaboration with an error.

All enabled banks share one clock enable and one synchronous clear. Clear takes priority over the enable.

Top module: `pipe_mult27`

## Requirements
- R1: `p_out` is the full signed product of `a_in` and `b_in`, with no truncation. This holds for the extreme pairs (-2^26)·(-2^26) = 2^52, (2^26-1)·(2^26-1) and (-2^26)·(2^26-1).
- R2: With `ce` held high, the product of the operands presented before rising edge k appears on `p_out` after rising edge k+LATENCY-1. With LATENCY=2 the operand and result banks are enabled. With LATENCY=4 all four banks are enabled.
- R3: VARIANT selects the bank placement for latencies 1 and 3. For LATENCY=1, variant 0 uses the operand bank only and variant 1 uses the result bank only. For LATENCY=3, variant 0 uses the operand, partial-product and result banks, and variant 1 uses the operand, combined-product and result banks. Both variants of a latency show the same timing at the ports.
- R4: When `ce` is low and `clr` is low, every enabled bank holds its value. The product sequence then resumes in order, with no value lost or repeated, once `ce` returns high.
- R5: When `clr` is high at a rising edge, every enabled bank is zeroed, whether or not `ce` is high. With LATENCY ≥ 1, `p_out` reads 0 until new operands have travelled through the pipeline.
- R6: With LATENCY=0 there is no register: `p_out` follows the operands combinationally, and `clk`, `ce` and `clr` have no effect.
- R7: The partial products split `b_in` at bit 18. The low 18 bits are treated as unsigned and the upper 9 bits as signed. The recombined product is exact, including operands whose low field is all ones or whose upper field is negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of all enabled banks, active high, priority over `ce` |
| ce | input | 1 | Clock enable for all enabled banks |
| a_in | input | 27 | First operand, two's complement |
| b_in | input | 27 | Second operand, two's complement |
| p_out | output | 54 | Signed product |

## Verification
The assertions assume that `clr` is pulsed at least once before the results matter. Until then each bank is unarmed and its checks are disabled. They also assume that `ce` and the operands change only away from the rising edge. The stimulus starts with a clear and drives every input on the falling edge. It covers extreme operands, operands that straddle the 18-bit split, random operands under a steady and a random `ce`, and a clear issued while `ce` is low. Seven instances, one for each legal latency/variant pair, receive identical stimulus. A single delay-line model therefore predicts all of them.

// File: rtl/pm_pkg.sv
package pm_pkg;

  // Bank mask bit positions: [0] operand, [1] partial, [2] combined, [3] result
  localparam int BANK_OPND = 0;
  localparam int BANK_PART = 1;
  localparam int BANK_COMB = 2;
  localparam int BANK_RSLT = 3;

  function automatic logic [3:0] bank_mask(input int lat, input int var_sel);
    logic [3:0] m;
    case (lat)
      0:       m = 4'b0000;
      1:       m = (var_sel == 1) ? 4'b1000 : 4'b0001;
      2:       m = 4'b1001;
      3:       m = (var_sel == 1) ? 4'b1101 : 4'b1011;
      4:       m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

  function automatic bit cfg_ok(input int lat, input int var_sel,
                                input int aw, input int bw, input int split);
    bit ok;
    ok = (lat >= 0) && (lat <= 4);
    if (var_sel == 1) ok = ok && ((lat == 1) || (lat == 3));
    else if (var_sel != 0) ok = 1'b0;
    ok = ok && (split > 0) && (split < bw - 1) && (aw > 1);
    return ok;
  endfunction

endpackage

// File: rtl/pm_stage_reg.sv
module pm_stage_reg #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      logic         armed = 1'b0;

      always_ff @(posedge clk) begin
        if (clr)     q_r <= '0;
        else if (ce) q_r <= d;
      end

      always_ff @(posedge clk) begin
        if (clr) armed <= 1'b1;
      end

      assign q = q_r;

      // R4: a stalled bank keeps its contents
      assert_bank_hold_R4: assert property (@(posedge clk) disable iff (clr || !armed)
        !ce |=> $stable(q_r));

      // R5: clear empties the bank whatever ce is
      assert_bank_clear_R5: assert property (@(posedge clk) disable iff (!armed)
        clr |=> (q_r == '0));
    end else begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ^{clk, clr, ce};
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/pm_split_mul.sv
module pm_split_mul #(
  parameter int AW    = 27,
  parameter int BW    = 27,
  parameter int SPLIT = 18,
  localparam int LO_W = AW + SPLIT + 1,
  localparam int HI_W = AW + BW - SPLIT
) (
  input  logic signed [AW-1:0]   a,
  input  logic signed [BW-1:0]   b,
  output logic signed [LO_W-1:0] pp_lo,
  output logic signed [HI_W-1:0] pp_hi
);

  logic signed [LO_W-1:0] a_lo_x, b_lo_x;
  logic signed [HI_W-1:0] a_hi_x, b_hi_x;
  logic signed [BW-SPLIT-1:0] b_top;

  assign b_top  = b[BW-1:SPLIT];
  assign a_lo_x = LO_W'(a);
  assign b_lo_x = LO_W'({1'b0, b[SPLIT-1:0]});
  assign a_hi_x = HI_W'(a);
  assign b_hi_x = HI_W'(b_top);

  assign pp_lo = a_lo_x * b_lo_x;
  assign pp_hi = a_hi_x * b_hi_x;

endmodule

// File: rtl/pm_combine.sv
module pm_combine #(
  parameter int AW    = 27,
  parameter int BW    = 27,
  parameter int SPLIT = 18,
  localparam int LO_W = AW + SPLIT + 1,
  localparam int HI_W = AW + BW - SPLIT,
  localparam int PW   = AW + BW
) (
  input  logic signed [LO_W-1:0] pp_lo,
  input  logic signed [HI_W-1:0] pp_hi,
  output logic signed [PW-1:0]   prod
);

  logic signed [PW-1:0] hi_shift, lo_ext;

  assign hi_shift = {pp_hi, {SPLIT{1'b0}}};
  assign lo_ext   = PW'(pp_lo);
  assign prod     = hi_shift + lo_ext;

endmodule

// File: rtl/pipe_mult27.sv
module pipe_mult27 #(
  parameter int A_W     = 27,
  parameter int B_W     = 27,
  parameter int SPLIT   = 18,
  parameter int LATENCY = 4,
  parameter int VARIANT = 0
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    ce,
  input  logic signed [A_W-1:0]   a_in,
  input  logic signed [B_W-1:0]   b_in,
  output logic signed [A_W+B_W-1:0] p_out
);
  import pm_pkg::*;

  localparam int   PW   = A_W + B_W;
  localparam int   LO_W = A_W + SPLIT + 1;
  localparam int   HI_W = A_W + B_W - SPLIT;
  localparam logic [3:0] MASK = bank_mask(LATENCY, VARIANT);
  localparam bit   EN_OPND = MASK[BANK_OPND];
  localparam bit   EN_PART = MASK[BANK_PART];
  localparam bit   EN_COMB = MASK[BANK_COMB];
  localparam bit   EN_RSLT = MASK[BANK_RSLT];

  generate
    if (!cfg_ok(LATENCY, VARIANT, A_W, B_W, SPLIT)) begin : g_bad_cfg
      $error("pipe_mult27: unsupported latency/variant or width setting");
    end
  endgenerate

  // operand bank
  logic [A_W+B_W-1:0]    opnd_d, opnd_q;
  logic signed [A_W-1:0] a_q;
  logic signed [B_W-1:0] b_q;

  assign opnd_d = {a_in, b_in};

  pm_stage_reg #(.W(A_W + B_W), .EN(EN_OPND)) u_opnd (
    .clk(clk), .clr(clr), .ce(ce), .d(opnd_d), .q(opnd_q));

  assign a_q = opnd_q[A_W+B_W-1:B_W];
  assign b_q = opnd_q[B_W-1:0];

  // split multiply and partial-product bank
  logic signed [LO_W-1:0] pp_lo, pp_lo_q;
  logic signed [HI_W-1:0] pp_hi, pp_hi_q;
  logic [LO_W+HI_W-1:0]   part_d, part_q;

  pm_split_mul #(.AW(A_W), .BW(B_W), .SPLIT(SPLIT)) u_split (
    .a(a_q), .b(b_q), .pp_lo(pp_lo), .pp_hi(pp_hi));

  assign part_d = {pp_hi, pp_lo};

  pm_stage_reg #(.W(LO_W + HI_W), .EN(EN_PART)) u_part (
    .clk(clk), .clr(clr), .ce(ce), .d(part_d), .q(part_q));

  assign pp_hi_q = part_q[LO_W+HI_W-1:LO_W];
  assign pp_lo_q = part_q[LO_W-1:0];

  // recombination, combined-product bank, result bank
  logic signed [PW-1:0] comb_p;
  logic [PW-1:0]        comb_q, rslt_q;

  pm_combine #(.AW(A_W), .BW(B_W), .SPLIT(SPLIT)) u_comb (
    .pp_lo(pp_lo_q), .pp_hi(pp_hi_q), .prod(comb_p));

  pm_stage_reg #(.W(PW), .EN(EN_COMB)) u_combreg (
    .clk(clk), .clr(clr), .ce(ce), .d(comb_p), .q(comb_q));

  pm_stage_reg #(.W(PW), .EN(EN_RSLT)) u_rslt (
    .clk(clk), .clr(clr), .ce(ce), .d(comb_q), .q(rslt_q));

  assign p_out = rslt_q;

  // ---------------- checks ----------------
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (clr) armed <= 1'b1;
  end

  logic signed [PW-1:0] ref_q, ref_in;
  assign ref_q  = PW'(a_q) * PW'(b_q);
  assign ref_in = PW'(a_in) * PW'(b_in);

  generate
    if (!EN_PART) begin : g_chk_direct
      // R7: split-and-recombine equals the plain product
      assert_split_direct_R7: assert property (@(posedge clk) disable iff (!armed)
        comb_p == ref_q);
    end else begin : g_chk_piped
      // R7: recombined partials equal the product of the operands one stage back
      assert_split_piped_R7: assert property (@(posedge clk) disable iff (!armed || clr)
        ($past(ce) && !$past(clr)) |-> (comb_p == $past(ref_q)));
    end
    if (LATENCY == 0) begin : g_chk_comb
      // R6: no register on the path
      assert_comb_path_R6: assert property (@(posedge clk) disable iff (!armed)
        p_out == ref_in);
    end
  endgenerate

endmodule

// File: tb/pipe_mult27_tb.sv
module pipe_mult27_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_CFG = 7;
  localparam int AW = 27;
  localparam int BW = 27;
  localparam int PW = AW + BW;
  localparam int CFG_LAT [N_CFG] = '{0, 1, 1, 2, 3, 3, 4};
  localparam int CFG_VAR [N_CFG] = '{0, 0, 1, 0, 0, 1, 0};
  localparam logic signed [AW-1:0] MAXP = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINN = {1'b1, {(AW-1){1'b0}}};

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic clr = 1'b1;
  logic ce  = 1'b0;
  logic signed [AW-1:0] a_in = '0;
  logic signed [BW-1:0] b_in = '0;
  logic signed [PW-1:0] prod_w [N_CFG];

  for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
    pipe_mult27 #(.LATENCY(CFG_LAT[i]), .VARIANT(CFG_VAR[i])) u_dut (
      .clk(clk), .clr(clr), .ce(ce), .a_in(a_in), .b_in(b_in), .p_out(prod_w[i]));
  end

  // behavioural reference: a delay line of exact products
  longint hist [4];
  bit     armed = 0;
  int     total = 0;
  int     bad = 0;
  bit     done = 0;
  string  tag = "R5";

  function automatic longint full_prod(input logic signed [AW-1:0] a,
                                       input logic signed [BW-1:0] b);
    return longint'(a) * longint'(b);
  endfunction

  always @(posedge clk) begin
    if (clr) begin
      armed = 1;
      for (int k = 0; k < 4; k++) hist[k] = 0;
    end else if (ce) begin
      for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = full_prod(a_in, b_in);
    end
  end

  task automatic check_all();
    if (!armed) return;
    for (int i = 0; i < N_CFG; i++) begin
      longint exp_v, got_v;
      string  t;
      exp_v = (CFG_LAT[i] == 0) ? full_prod(a_in, b_in) : hist[CFG_LAT[i]-1];
      got_v = longint'(prod_w[i]);
      t = (CFG_LAT[i] == 0) ? "R6" : ((CFG_VAR[i] == 1) ? "R3" : tag);
      total++;
      if (got_v !== exp_v) begin
        bad++;
        $display("FAIL %s lat=%0d var=%0d got=%0d exp=%0d", t, CFG_LAT[i], CFG_VAR[i],
                 got_v, exp_v);
      end
    end
  endtask

  // check the current cycle, then drive the next inputs, all on the falling edge
  task automatic step(input logic signed [AW-1:0] a, input logic signed [BW-1:0] b,
                      input logic c, input logic r);
    @(negedge clk);
    check_all();
    a_in = a; b_in = b; ce = c; clr = r;
  endtask

  task automatic flush(input int n);
    for (int k = 0; k < n; k++) step('0, '0, 1'b1, 1'b0);
  endtask

  initial begin
    // R5: clear from time zero, then check the reset state
    tag = "R5";
    step('0, '0, 1'b0, 1'b1);
    step(27'sd5, 27'sd7, 1'b0, 1'b1);
    step(27'sd5, 27'sd7, 1'b0, 1'b0);

    // R1: extreme operands
    tag = "R1";
    step(MINN, MINN, 1'b1, 1'b0);
    step(MAXP, MAXP, 1'b1, 1'b0);
    step(MINN, MAXP, 1'b1, 1'b0);
    step(MAXP, MINN, 1'b1, 1'b0);
    step(-27'sd1, -27'sd1, 1'b1, 1'b0);
    step(MINN, 27'sd1, 1'b1, 1'b0);
    step(27'sd0, MINN, 1'b1, 1'b0);
    flush(5);

    // R7: operands straddling the 18-bit split of b
    tag = "R7";
    step(27'sd12345, 27'sh003FFFF, 1'b1, 1'b0);
    step(-27'sd77, 27'sh003FFFF, 1'b1, 1'b0);
    step(MAXP, 27'sh7FC0000, 1'b1, 1'b0);
    step(MINN, 27'sh7FFFFFF, 1'b1, 1'b0);
    step(-27'sd3, 27'sh0040000, 1'b1, 1'b0);
    step(27'sd99, 27'sh4000001, 1'b1, 1'b0);
    flush(5);

    // R2: random operands, ce high
    tag = "R2";
    for (int k = 0; k < 300; k++) step(AW'($urandom), BW'($urandom), 1'b1, 1'b0);
    flush(5);

    // R4: random operands with stalls
    tag = "R4";
    for (int k = 0; k < 400; k++)
      step(AW'($urandom), BW'($urandom), (($urandom % 3) != 0), 1'b0);
    step(27'sd11, 27'sd13, 1'b0, 1'b0);
    step(27'sd17, 27'sd19, 1'b0, 1'b0);
    flush(5);

    // R5: clear issued while ce is low, in the middle of a stream
    tag = "R5";
    for (int k = 0; k < 3; k++) step(AW'($urandom), BW'($urandom), 1'b1, 1'b0);
    step(AW'($urandom), BW'($urandom), 1'b0, 1'b1);
    step(27'sd21, 27'sd23, 1'b0, 1'b0);
    step(27'sd21, 27'sd23, 1'b1, 1'b0);
    for (int k = 0; k < 60; k++)
      step(AW'($urandom), BW'($urandom), 1'b1, (($urandom % 9) == 0));
    flush(6);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R2 watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule